// File: doc/BRIEF.md
# SPI Slave Hold Controller

This block gives an SPI slave its pause function. It runs on a fast system clock and oversamples three slave-side pins: the serial clock, the active-low chip select and an active-low hold request. From these it derives a registered hold flag, single-cycle strobes for the rising and falling serial-clock edges, a data-output enable, and the current bit position inside the byte being transferred.

While the hold flag is set, no serial-clock edge is passed on to the slave datapath and the output enable is forced off, so the slave can tri-state its data line. The bit position is neither advanced nor cleared, so the transfer resumes at the bit where it stopped. Hold starts and ends only while the serial clock is low. A change of the hold pin during the high phase takes effect once the clock falls. If the master deselects the slave during a hold, the block issues a one-cycle protocol-reset pulse so that the slave discards the interrupted command.

Top module: `spi_hold_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hold_active`, `proto_rst` and `bit_pos` are all 0.
- R2: If `cs_n` is 0, `hold_n` is 0 and `sck` is 0 at a clock edge, `hold_active` is 1 after that edge.
- R3: While `cs_n` is 1, `hold_active` never becomes 1, whatever `hold_n` and `sck` do.
- R4: If `hold_n` goes low while `sck` is high, `hold_active` stays 0 until `sck` is sampled low. It then sets one cycle later.
- R5: If `hold_active` is 1 and `hold_n` is 1 and `sck` is 0 at a clock edge, `hold_active` is 0 after that edge.
- R6: If `hold_n` returns high while `sck` is high, `hold_active` stays 1 until `sck` is sampled low.
- R7: `sdo_oe` equals `slave_oe` AND NOT `cs_n` AND NOT `hold_active`. It is 0 for the whole hold.
- R8: `rise_stb` is 1 when `sck` is 1 now and was 0 at the previous edge. `fall_stb` is 1 for the opposite change. Both strobes are 0 while `cs_n` is 1 or `hold_active` is 1.
- R9: `bit_pos` advances by one after each edge on which `rise_stb` is 1, and wraps from BITS-1 to 0 (BITS defaults to 8). It keeps its value for the whole hold.
- R10: An edge that sees `cs_n` high clears `hold_active` and sets `bit_pos` to 0 after that edge.
- R11: `proto_rst` is 1 for exactly the cycle after an edge that sees `cs_n` high with `hold_active` 1. A deselect without a hold never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, already synchronized to `clk` |
| cs_n | input | 1 | Active-low chip select, already synchronized |
| hold_n | input | 1 | Active-low hold request, already synchronized |
| slave_oe | input | 1 | Slave datapath requests to drive its data output |
| hold_active | output | 1 | Registered hold flag |
| sdo_oe | output | 1 | Gated data-output enable |
| rise_stb | output | 1 | Serial-clock rising-edge strobe for the datapath |
| fall_stb | output | 1 | Serial-clock falling-edge strobe for the datapath |
| bit_pos | output | $clog2(BITS) | Bit position within the current byte |
| proto_rst | output | 1 | One-cycle reset pulse after a deselect during hold |

## Verification
The assertions assume that `sck`, `cs_n` and `hold_n` arrive already synchronized to `clk`. They also assume that every serial-clock level is held for at least one system cycle, so that each edge is seen exactly once. The stimulus changes inputs only away from the sampling edge and holds each `sck` level for two system cycles. It moves `hold_n` in both clock phases so that the deferred-entry and deferred-exit paths are reached. It also deselects both inside and outside a hold, which exercises the reset pulse and the cleared bit position.

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl #(
  parameter int BITS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sck,
  input  logic                      cs_n,
  input  logic                      hold_n,
  input  logic                      slave_oe,
  output logic                      hold_active,
  output logic                      sdo_oe,
  output logic                      rise_stb,
  output logic                      fall_stb,
  output logic [$clog2(BITS)-1:0]   bit_pos,
  output logic                      proto_rst
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic sck_q;
  logic live;
  logic enter, leave;

  assign live     = !cs_n && !hold_active;
  assign rise_stb = live &&  sck && !sck_q;
  assign fall_stb = live && !sck &&  sck_q;
  assign sdo_oe   = slave_oe && live;
  assign enter    = !hold_active && !hold_n && !sck;
  assign leave    =  hold_active &&  hold_n && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q       <= 1'b0;
      hold_active <= 1'b0;
      proto_rst   <= 1'b0;
      bit_pos     <= '0;
    end else begin
      sck_q     <= sck;
      proto_rst <= cs_n && hold_active;
      if (cs_n) begin
        hold_active <= 1'b0;
        bit_pos     <= '0;
      end else begin
        if (enter)      hold_active <= 1'b1;
        else if (leave) hold_active <= 1'b0;
        if (rise_stb)   bit_pos <= (bit_pos == LAST) ? '0 : bit_pos + 1'b1;
      end
    end
  end
endmodule

module spi_hold_ctl_chk #(
  parameter int BITS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sck,
  input logic                    cs_n,
  input logic                    hold_n,
  input logic                    hold_active,
  input logic                    sdo_oe,
  input logic                    rise_stb,
  input logic                    fall_stb,
  input logic [$clog2(BITS)-1:0] bit_pos,
  input logic                    proto_rst
);
  AST_ENTRY_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!cs_n)); // R3
  AST_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!sck && !hold_n)); // R2
  AST_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> $past(cs_n || (hold_n && !sck))); // R5
  AST_NO_OE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !sdo_oe); // R7
  AST_NO_STROBE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !(rise_stb || fall_stb)); // R8
  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_active) && !$past(cs_n)) |-> $stable(bit_pos)); // R9
  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!hold_active && bit_pos == '0)); // R10
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_rst |-> $past(cs_n && hold_active)); // R11
endmodule

bind spi_hold_ctl spi_hold_ctl_chk #(.BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
  .hold_active(hold_active), .sdo_oe(sdo_oe), .rise_stb(rise_stb),
  .fall_stb(fall_stb), .bit_pos(bit_pos), .proto_rst(proto_rst)
);

// File: tb/sim_spi_hold_ctl.sv
`timescale 1ns/1ps
module sim_spi_hold_ctl;
  localparam int BITS = 8;
  localparam int CW = $clog2(BITS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, slave_oe = 1'b0;
  logic hold_active, sdo_oe, rise_stb, fall_stb, proto_rst;
  logic [CW-1:0] bit_pos;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_hold = 0, m_prev = 0, m_pos = 0, m_rst = 0;

  always #2.5 clk = ~clk;

  spi_hold_ctl #(.BITS(BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .slave_oe(slave_oe), .hold_active(hold_active), .sdo_oe(sdo_oe),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .bit_pos(bit_pos),
    .proto_rst(proto_rst)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(input bit s, input bit cs, input bit h, input bit oe, input string tag);
    int rise, fall, live;
    @(negedge clk);
    sck = s; cs_n = cs; hold_n = h; slave_oe = oe;
    #1;
    live = (!cs && !m_hold) ? 1 : 0;
    rise = (live && s && !m_prev) ? 1 : 0;
    fall = (live && !s && m_prev) ? 1 : 0;
    vectors++;
    cmp(tag, "hold_active", int'(hold_active), m_hold);
    cmp(tag, "sdo_oe", int'(sdo_oe), (oe && live) ? 1 : 0);
    cmp(tag, "rise_stb", int'(rise_stb), rise);
    cmp(tag, "fall_stb", int'(fall_stb), fall);
    cmp(tag, "bit_pos", int'(bit_pos), m_pos);
    cmp(tag, "proto_rst", int'(proto_rst), m_rst);
    @(posedge clk);
    if (rst_n) begin
      m_rst = (cs && m_hold) ? 1 : 0;
      if (cs) begin
        m_hold = 0; m_pos = 0;
      end else begin
        if (!m_hold && !h && !s) m_hold = 1;
        else if (m_hold && h && !s) m_hold = 0;
        if (rise) m_pos = (m_pos + 1) % BITS;
      end
      m_prev = s;
    end
  endtask

  task automatic expect_hold(input int exp, input string tag);
    @(negedge clk); #1;
    vectors++;
    cmp(tag, "hold_active(direct)", int'(hold_active), exp);
  endtask

  task automatic sbit(input bit h, input string tag);
    tick(0, 0, h, 1, tag); tick(0, 0, h, 1, tag);
    tick(1, 0, h, 1, tag); tick(1, 0, h, 1, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) tick(0, 1, 1, 0, "R1");
    rst_n = 1'b1;
    tick(0, 1, 1, 0, "R1");
    // R3 hold request while deselected
    for (int i = 0; i < 4; i++) tick(0, 1, 0, 1, "R3");
    tick(1, 1, 0, 1, "R3");
    tick(0, 1, 1, 0, "R3");
    // R7 R8 R9 three bits shifted
    for (int i = 0; i < 3; i++) sbit(1, "R9");
    // R2 enter with sck low
    tick(0, 0, 1, 1, "R2");
    tick(0, 0, 0, 1, "R2");
    tick(0, 0, 0, 1, "R2");
    expect_hold(1, "R2");
    // R8 R9 clock toggles ignored while held
    for (int i = 0; i < 3; i++) sbit(0, "R8");
    // R6 release while sck high is deferred
    tick(1, 0, 1, 1, "R6");
    tick(1, 0, 1, 1, "R6");
    expect_hold(1, "R6");
    // R5 exit when sck falls
    tick(0, 0, 1, 1, "R5");
    tick(0, 0, 1, 1, "R5");
    expect_hold(0, "R5");
    // R9 continue to wrap past BITS
    for (int i = 0; i < 7; i++) sbit(1, "R9");
    // R4 hold request with sck high deferred
    tick(1, 0, 0, 1, "R4");
    tick(1, 0, 0, 1, "R4");
    expect_hold(0, "R4");
    tick(0, 0, 0, 1, "R4");
    tick(0, 0, 0, 1, "R4");
    expect_hold(1, "R4");
    // R11 R10 deselect during hold
    tick(0, 1, 0, 1, "R11");
    tick(0, 1, 1, 1, "R11");
    tick(0, 1, 1, 1, "R10");
    // R11 deselect without hold gives no pulse
    tick(0, 0, 1, 1, "R11");
    sbit(1, "R11");
    tick(0, 1, 1, 1, "R11");
    tick(0, 1, 1, 1, "R11");
    tick(0, 1, 1, 0, "R10");
    // R1 mid-run reset
    tick(0, 0, 1, 1, "R1");
    tick(0, 0, 0, 1, "R1");
    @(negedge clk); rst_n = 1'b0;
    m_hold = 0; m_prev = 0; m_pos = 0; m_rst = 0;
    tick(0, 0, 1, 1, "R1");
    @(negedge clk); rst_n = 1'b1;
    tick(0, 0, 1, 1, "R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule